// File: doc/BRIEF.md
# LF Telegram Bit Sequencer

This block plays out a low-frequency telegram for an eight-channel antenna driver. Data is held in two 56-bit buffers that alternate as the telegram runs. Each buffer is sent most significant bit first, at one of two baud rates. While one buffer is on air, software can refill the other, so a telegram can run without end. When a buffer runs out and the other one was never refilled, the telegram stops and the block reports ready again.

Every channel gets a drive command each bit: an activity kind, an amplitude code and a phase select. The two lowest-numbered data channels send the bit stream as carrier on or off. For a window of the telegram counted in bytes and bits, they use a secondary amplitude instead of the primary one. Channels set for suppression bits stay grounded, except for a short reduced-amplitude burst at a programmed bit position. The drive commands go to the waveform synthesiser and the bridge control, which are outside this block.

Top module: `lf_telegram_seq`

## Requirements
- R1: After reset, `seq_status` is 00 and every channel reports kind 00 with amplitude 0 and phase 0.
- R2: Each buffer is sent from bit 55 down to bit 0. A bit lasts TICKS_FAST enabled clocks when `baud_fast`=1 and TICKS_SLOW enabled clocks when `baud_fast`=0.
- R3: With `autosend`=0, a `start_cmd` pulse while ready starts the telegram from buffer 1, provided buffer 1 holds data. Bit 0 is driven from the next cycle. A pulse while buffer 1 is empty is ignored.
- R4: With `autosend`=1, an accepted write to buffer 1 (`buf_wr[0]`) while ready starts the telegram on that same edge, with the new data.
- R5: `seq_status` is 00 when ready, 10 while buffer 1 is on air and 11 while buffer 2 is on air. At the end of a buffer, transmission moves to the other buffer if that buffer was written since it was last sent. Otherwise the block returns to 00.
- R6: A write to the buffer on air is ignored. A write to the other buffer is accepted during transmission.
- R7: Channel mode (2 bits per channel) decodes as follows:
  - 00: kind 00, low side held.
  - 01 and 10: data channels. Kind 10 (carrier) on a 1 bit and kind 01 (biased, no carrier) on a 0 bit. Phase is 1 for mode 01 (180°) and 0 for mode 10 (0°).
  - 11: suppression-burst channel.
- R8: Only the two lowest-indexed data channels transmit. Further data channels report kind 00.
- R9: Data channels use `gain_sec` for telegram bit indexes from 8·`sec_start_bytes` up to, but not including, 8·`sec_start_bytes`+`sec_len_bits`. They use `gain_pri` for all other bits. A length of 0 means `gain_pri` for the whole telegram.
- R10: Mode-11 channels report kind 11, with amplitude `gain_dst` zero-extended, for telegram bits from S to S+`dst_len_code`, where S = max(`dst_start_bits`, 2). They report kind 00 otherwise.
- R11: While ready, every channel reports kind 00 with amplitude 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Internal clock enable that paces the bit timer |
| baud_fast | input | 1 | 1 = fast bit rate, 0 = slow bit rate |
| autosend | input | 1 | Start on a complete write to buffer 1 |
| start_cmd | input | 1 | Start pulse when not in autosend |
| buf_wr | input | 2 | Write strobes: bit 0 for buffer 1, bit 1 for buffer 2 |
| buf_wdata | input | 56 | Buffer write data |
| ch_mode | input | 16 | 2-bit mode per channel; channel i at [2i+1:2i] |
| gain_pri | input | 5 | Primary amplitude code |
| gain_sec | input | 5 | Secondary amplitude code |
| gain_dst | input | 4 | Suppression-burst amplitude code |
| sec_start_bytes | input | 6 | Start of the secondary window, in bytes |
| sec_len_bits | input | 7 | Length of the secondary window, in bits |
| dst_start_bits | input | 6 | Telegram bit where the burst starts |
| dst_len_code | input | 2 | Burst length minus one, in bits |
| seq_status | output | 2 | 00 ready, 10 buffer 1 on air, 11 buffer 2 on air |
| ch_kind | output | 16 | 2-bit activity kind per channel |
| ch_amp | output | 40 | 5-bit amplitude code per channel |
| ch_phase | output | 8 | Phase select per channel, 1 = 180° |

## Verification
All outputs are decoded without further delay from state registers, and those registers update on the start edge and on each bit boundary. If s is the edge that samples the start, bit k of the telegram is visible from edge s+k·T for T cycles, and the return to ready appears at edge s+n·T for an n-bit telegram. The driver computes these due cycles when it queues each expected bit, and the monitor compares at the falling edge in the middle of each bit. A dropped or extra bit, or a shift in the rate, therefore shows up as a mismatch. The checks for ignored writes, for a start with no data and for the end-of-telegram return are taken at fixed cycle offsets from the stimulus.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

    typedef enum logic [1:0] {
        CH_LOW     = 2'b00,
        CH_MID     = 2'b01,
        CH_CARRIER = 2'b10,
        CH_DESTROY = 2'b11
    } ch_kind_e;

    typedef enum logic [1:0] {
        MD_HOLD    = 2'b00,
        MD_TX180   = 2'b01,
        MD_TX0     = 2'b10,
        MD_DESTROY = 2'b11
    } ch_mode_e;

    typedef struct packed {
        logic busy;
        logic act;
    } seq_state_t;

    function automatic logic mode_is_data(logic [1:0] m);
        return (m == MD_TX180) || (m == MD_TX0);
    endfunction

    function automatic int unsigned burst_first(int unsigned v);
        return (v < 2) ? 2 : v;
    endfunction

endpackage

// File: rtl/lfs_pingpong.sv
module lfs_pingpong #(
    parameter int BUF_W = 56,
    localparam int PTR_W = $clog2(BUF_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       wr_en,
    input  logic [BUF_W-1:0] wdata,
    input  logic             busy,
    input  logic             act,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic             consume,
    output logic [1:0]       acc,
    output logic [1:0]       valid,
    output logic             rd_bit
);
    logic [BUF_W-1:0] mem_q [2];

    for (genvar i = 0; i < 2; i++) begin : g_buf
        assign acc[i] = wr_en[i] && !(busy && (act == 1'(i)));

        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[i] <= '0;
                valid[i] <= 1'b0;
            end else if (acc[i]) begin
                mem_q[i] <= wdata;
                valid[i] <= 1'b1;
            end else if (consume && (act == 1'(i))) begin
                valid[i] <= 1'b0;
            end
        end

        // R6
        active_frozen_chk: assert property (@(posedge clk) disable iff (rst)
            (busy && (act == 1'(i))) |=> $stable(mem_q[i]));
    end

    assign rd_bit = mem_q[act][rd_ptr];

endmodule

// File: rtl/lfs_baud.sv
module lfs_baud #(
    parameter int TICKS_FAST = 128,
    parameter int TICKS_SLOW = 256,
    localparam int TMAX = (TICKS_SLOW > TICKS_FAST) ? TICKS_SLOW : TICKS_FAST,
    localparam int CW   = $clog2(TMAX + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick_en,
    input  logic fast,
    output logic bit_stb
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_val;

    assign last_val = fast ? CW'(TICKS_FAST - 1) : CW'(TICKS_SLOW - 1);
    assign bit_stb  = run && tick_en && (cnt_q >= last_val);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (bit_stb) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2
    tick_range_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < CW'(TMAX)));

endmodule

// File: rtl/lfs_chan.sv
module lfs_chan
    import lfs_pkg::*;
#(
    parameter int GAIN_W  = 5,
    parameter int DGAIN_W = 4
) (
    input  logic [1:0]         mode,
    input  logic               slot_ok,
    input  logic               busy,
    input  logic               bit_val,
    input  logic               use_sec,
    input  logic               in_burst,
    input  logic [GAIN_W-1:0]  gain_pri,
    input  logic [GAIN_W-1:0]  gain_sec,
    input  logic [DGAIN_W-1:0] gain_dst,
    output ch_kind_e           kind,
    output logic [GAIN_W-1:0]  amp,
    output logic               phase
);
    always_comb begin
        kind  = CH_LOW;
        amp   = '0;
        phase = 1'b0;
        if (busy) begin
            if (mode_is_data(mode) && slot_ok) begin
                kind  = bit_val ? CH_CARRIER : CH_MID;
                amp   = use_sec ? gain_sec : gain_pri;
                phase = (mode == MD_TX180);
            end else if ((mode == MD_DESTROY) && in_burst) begin
                kind = CH_DESTROY;
                amp  = GAIN_W'(gain_dst);
            end
        end
    end

endmodule

// File: rtl/lf_telegram_seq.sv
module lf_telegram_seq
    import lfs_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int BUF_W      = 56,
    parameter int GAIN_W     = 5,
    parameter int DGAIN_W    = 4,
    parameter int G2S_W      = 6,
    parameter int G2L_W      = 7,
    parameter int DST_W      = 6,
    parameter int TICKS_FAST = 128,
    parameter int TICKS_SLOW = 256
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick_en,
    input  logic                     baud_fast,
    input  logic                     autosend,
    input  logic                     start_cmd,
    input  logic [1:0]               buf_wr,
    input  logic [BUF_W-1:0]         buf_wdata,
    input  logic [2*NUM_CH-1:0]      ch_mode,
    input  logic [GAIN_W-1:0]        gain_pri,
    input  logic [GAIN_W-1:0]        gain_sec,
    input  logic [DGAIN_W-1:0]       gain_dst,
    input  logic [G2S_W-1:0]         sec_start_bytes,
    input  logic [G2L_W-1:0]         sec_len_bits,
    input  logic [DST_W-1:0]         dst_start_bits,
    input  logic [1:0]               dst_len_code,
    output logic [1:0]               seq_status,
    output logic [2*NUM_CH-1:0]      ch_kind,
    output logic [GAIN_W*NUM_CH-1:0] ch_amp,
    output logic [NUM_CH-1:0]        ch_phase
);
    localparam int PTR_W = $clog2(BUF_W);
    localparam int CNT_W = $clog2(((2**G2S_W) - 1) * 8 + (2**G2L_W) + (2**DST_W) + 4) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(BUF_W - 1);

    seq_state_t       st_q;
    logic [PTR_W-1:0] ptr_q;
    logic [CNT_W-1:0] bitn_q;

    logic [1:0] wr_acc;
    logic [1:0] vld;
    logic       rd_bit;
    logic       bit_stb;
    logic       start_ev;
    logic       last_bit;
    logic       consume;
    logic       other;

    assign other    = ~st_q.act;
    assign last_bit = (ptr_q == '0);
    assign consume  = st_q.busy && bit_stb && last_bit;
    assign start_ev = !st_q.busy &&
                      ((autosend && wr_acc[0]) || (!autosend && start_cmd && vld[0]));

    lfs_pingpong #(.BUF_W(BUF_W)) u_bufs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (buf_wr),
        .wdata   (buf_wdata),
        .busy    (st_q.busy),
        .act     (st_q.act),
        .rd_ptr  (ptr_q),
        .consume (consume),
        .acc     (wr_acc),
        .valid   (vld),
        .rd_bit  (rd_bit)
    );

    lfs_baud #(.TICKS_FAST(TICKS_FAST), .TICKS_SLOW(TICKS_SLOW)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .run     (st_q.busy),
        .tick_en (tick_en),
        .fast    (baud_fast),
        .bit_stb (bit_stb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            ptr_q  <= '0;
            bitn_q <= '0;
        end else if (start_ev) begin
            st_q.busy <= 1'b1;
            st_q.act  <= 1'b0;
            ptr_q     <= PTR_TOP;
            bitn_q    <= '0;
        end else if (st_q.busy && bit_stb) begin
            if (bitn_q != CNT_MAX) begin
                bitn_q <= bitn_q + 1'b1;
            end
            if (last_bit) begin
                if (vld[other]) begin
                    st_q.act <= other;
                    ptr_q    <= PTR_TOP;
                end else begin
                    st_q.busy <= 1'b0;
                end
            end else begin
                ptr_q <= ptr_q - 1'b1;
            end
        end
    end

    // secondary-gain window and suppression burst window, in telegram bits
    logic [CNT_W-1:0] sec_lo, sec_hi, dst_lo, dst_hi;
    logic             use_sec, in_burst;

    assign sec_lo   = CNT_W'(sec_start_bytes) << 3;
    assign sec_hi   = sec_lo + CNT_W'(sec_len_bits);
    assign use_sec  = (sec_len_bits != '0) && (bitn_q >= sec_lo) && (bitn_q < sec_hi);
    assign dst_lo   = CNT_W'(burst_first(32'(dst_start_bits)));
    assign dst_hi   = dst_lo + CNT_W'(dst_len_code) + 1'b1;
    assign in_burst = (bitn_q >= dst_lo) && (bitn_q < dst_hi);

    assign seq_status = st_q.busy ? {1'b1, st_q.act} : 2'b00;

    // rank chain: number of data channels seen below each index, saturating at two
    logic [1:0]        rank [NUM_CH+1];
    ch_kind_e          kind_w [NUM_CH];
    logic [NUM_CH-1:0] data_on;
    logic [NUM_CH-1:0] dst_on;

    assign rank[0] = 2'd0;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [1:0] m;
        assign m = ch_mode[2*i +: 2];
        assign rank[i+1] = (mode_is_data(m) && (rank[i] != 2'd2)) ? rank[i] + 2'd1 : rank[i];

        lfs_chan #(.GAIN_W(GAIN_W), .DGAIN_W(DGAIN_W)) u_chan (
            .mode     (m),
            .slot_ok  (rank[i] != 2'd2),
            .busy     (st_q.busy),
            .bit_val  (rd_bit),
            .use_sec  (use_sec),
            .in_burst (in_burst),
            .gain_pri (gain_pri),
            .gain_sec (gain_sec),
            .gain_dst (gain_dst),
            .kind     (kind_w[i]),
            .amp      (ch_amp[GAIN_W*i +: GAIN_W]),
            .phase    (ch_phase[i])
        );

        assign ch_kind[2*i +: 2] = kind_w[i];
        assign data_on[i] = (kind_w[i] == CH_CARRIER) || (kind_w[i] == CH_MID);
        assign dst_on[i]  = (kind_w[i] == CH_DESTROY);
    end

    // R8
    two_data_max_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(data_on) <= 2);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !st_q.busy |-> (ch_kind == '0) && (ch_amp == '0));

    // R10
    burst_window_chk: assert property (@(posedge clk) disable iff (rst)
        (dst_on != '0) |-> in_burst);

    // R5
    end_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (consume && !vld[other] && !start_ev) |=> (seq_status == 2'b00));

endmodule

// File: tb/tb_lf_telegram_seq.sv
module tb_lf_telegram_seq;
    localparam int CLK_P = 10;
    localparam int TF = 4;
    localparam int TS = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b1;
    logic        baud_fast = 1'b1;
    logic        autosend = 1'b0;
    logic        start_cmd = 1'b0;
    logic [1:0]  buf_wr = 2'b00;
    logic [55:0] buf_wdata = '0;
    logic [15:0] ch_mode = '0;
    logic [4:0]  gain_pri = 5'd27, gain_sec = 5'd13;
    logic [3:0]  gain_dst = 4'd9;
    logic [5:0]  sec_start_bytes = '0;
    logic [6:0]  sec_len_bits = '0;
    logic [5:0]  dst_start_bits = 6'd2;
    logic [1:0]  dst_len_code = '0;
    logic [1:0]  seq_status;
    logic [15:0] ch_kind;
    logic [39:0] ch_amp;
    logic [7:0]  ch_phase;

    lf_telegram_seq #(.TICKS_FAST(TF), .TICKS_SLOW(TS)) dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .baud_fast(baud_fast),
        .autosend(autosend), .start_cmd(start_cmd), .buf_wr(buf_wr),
        .buf_wdata(buf_wdata), .ch_mode(ch_mode), .gain_pri(gain_pri),
        .gain_sec(gain_sec), .gain_dst(gain_dst), .sec_start_bytes(sec_start_bytes),
        .sec_len_bits(sec_len_bits), .dst_start_bits(dst_start_bits),
        .dst_len_code(dst_len_code), .seq_status(seq_status), .ch_kind(ch_kind),
        .ch_amp(ch_amp), .ch_phase(ch_phase)
    );

    always #(CLK_P/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        int          due;
        int          k;
        logic [1:0]  st;
        logic [15:0] kind;
        logic [39:0] amp;
        logic [7:0]  ph;
    } exp_t;

    exp_t q[$];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // expected model, computed from the requirements
    task automatic push_telegram(input int s, input int t, input int n,
                                 input logic [55:0] w0, input logic [55:0] w1, input logic [55:0] w2);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            int blk;
            int rank;
            int dfirst;
            logic [55:0] w;
            logic b, g2, bur;
            blk = k / 56;
            w = (blk == 0) ? w0 : ((blk == 1) ? w1 : w2);
            b = w[55 - (k % 56)];                                       // R2
            g2 = (sec_len_bits != 0) && (k >= 8*int'(sec_start_bytes)) &&
                 (k < 8*int'(sec_start_bytes) + int'(sec_len_bits));    // R9
            dfirst = (int'(dst_start_bits) < 2) ? 2 : int'(dst_start_bits);
            bur = (k >= dfirst) && (k < dfirst + int'(dst_len_code) + 1); // R10
            e.due = s + k*t + t/2;
            e.k = k;
            e.st = (blk % 2 == 0) ? 2'b10 : 2'b11;                      // R5
            e.kind = '0; e.amp = '0; e.ph = '0;
            rank = 0;
            for (int c = 0; c < 8; c++) begin
                logic [1:0] m;
                m = ch_mode[2*c +: 2];
                if (m == 2'b01 || m == 2'b10) begin
                    if (rank < 2) begin                                 // R8
                        e.kind[2*c +: 2] = b ? 2'b10 : 2'b01;           // R7
                        e.amp[5*c +: 5] = g2 ? gain_sec : gain_pri;
                        e.ph[c] = (m == 2'b01);
                    end
                    rank++;
                end else if (m == 2'b11 && bur) begin
                    e.kind[2*c +: 2] = 2'b11;
                    e.amp[5*c +: 5] = {1'b0, gain_dst};
                end
            end
            q.push_back(e);
        end
    endtask

    // monitor: compares each bit in its middle
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].due < cyc) begin
            check(1'b0, "R2 bit missed", 64'(cyc), 64'(q[0].due));
            void'(q.pop_front());
        end
        if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            check(seq_status == e.st, "R5 status", 64'(seq_status), 64'(e.st));
            check(ch_kind == e.kind, "R2 R6 R7 R8 R10 kind", 64'(ch_kind), 64'(e.kind));
            check(ch_amp == e.amp, "R9 R10 amp", 64'(ch_amp), 64'(e.amp));
            check(ch_phase == e.ph, "R7 phase", 64'(ch_phase), 64'(e.ph));
        end
    end

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog all-requirements act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    localparam logic [55:0] D1 = 56'hA50F3C96C35AF0;
    localparam logic [55:0] D2 = 56'h123456789ABCDE;
    localparam logic [55:0] D3 = 56'hFF00817E55AA01;
    localparam logic [55:0] DX = 56'h0F0F0F0F0F0F0F;
    localparam logic [55:0] D4 = 56'hC3A5965A0FF00F;

    initial begin
        int s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(seq_status == 2'b00, "R1 status", 64'(seq_status), 64'd0);
        check(ch_kind == '0 && ch_amp == '0 && ch_phase == '0, "R1 channels",
              64'(ch_kind), 64'd0);

        // telegram A: manual start, fast baud, endless across three buffers
        ch_mode = {2'b00, 2'b01, 2'b11, 2'b00, 2'b11, 2'b10, 2'b01, 2'b10};
        gain_pri = 5'd20; gain_sec = 5'd7; gain_dst = 4'd5;
        sec_start_bytes = 6'd1; sec_len_bits = 7'd5;
        dst_start_bits = 6'd0; dst_len_code = 2'd3;
        baud_fast = 1'b1;
        buf_wdata = D1; buf_wr = 2'b01; @(negedge clk);
        buf_wdata = D2; buf_wr = 2'b10; @(negedge clk);
        buf_wr = 2'b00;
        // R11: loaded but not started
        check(seq_status == 2'b00 && ch_kind == '0, "R11 idle before start",
              64'(ch_kind), 64'd0);
        s = cyc + 1;
        push_telegram(s, TF, 168, D1, D2, D3);
        start_cmd = 1'b1; @(negedge clk); start_cmd = 1'b0;
        // R3: started from buffer 1
        check(seq_status == 2'b10, "R3 start", 64'(seq_status), 64'h2);
        // R6: write to the buffer on air is dropped
        wait_cyc(s + 10*TF + 1);
        buf_wdata = DX; buf_wr = 2'b01; @(negedge clk); buf_wr = 2'b00;
        // R6: refill buffer 1 while buffer 2 is on air
        wait_cyc(s + 60*TF + 1);
        buf_wdata = D3; buf_wr = 2'b01; @(negedge clk); buf_wr = 2'b00;
        wait_cyc(s + 168*TF);
        // R5 R11: no refill of buffer 2, so ready after 168 bits
        check(seq_status == 2'b00, "R5 end of telegram", 64'(seq_status), 64'd0);
        check(ch_kind == '0 && ch_amp == '0, "R11 idle after end", 64'(ch_kind), 64'd0);
        check(q.size() == 0, "R2 all bits seen", 64'(q.size()), 64'd0);

        // telegram B: autosend, slow baud, no secondary window, one-bit burst
        ch_mode = {2'b01, 2'b11, 2'b00, 2'b00, 2'b10, 2'b00, 2'b11, 2'b00};
        gain_pri = 5'd27; gain_sec = 5'd13; gain_dst = 4'd9;
        sec_start_bytes = 6'd0; sec_len_bits = 7'd0;
        dst_start_bits = 6'd5; dst_len_code = 2'd0;
        baud_fast = 1'b0; autosend = 1'b1;
        @(negedge clk);
        s = cyc + 1;
        push_telegram(s, TS, 56, D4, D4, D4);
        buf_wdata = D4; buf_wr = 2'b01; @(negedge clk); buf_wr = 2'b00;
        // R4
        check(seq_status == 2'b10, "R4 autosend start", 64'(seq_status), 64'h2);
        wait_cyc(s + 56*TS);
        check(seq_status == 2'b00, "R5 single buffer end", 64'(seq_status), 64'd0);
        autosend = 1'b0;

        // R3: start with buffer 1 empty is ignored
        @(negedge clk);
        start_cmd = 1'b1; @(negedge clk); start_cmd = 1'b0;
        repeat (3) @(negedge clk);
        check(seq_status == 2'b00, "R3 start without data", 64'(seq_status), 64'd0);
        check(ch_kind == '0, "R11 still idle", 64'(ch_kind), 64'd0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule